// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake Timer

This block moves a small processor core between three operating states: run, idle and halt. Software asks for a low-power state with a one-cycle pulse on a request input. The block then waits through a short settling interval. After that it turns off the core clock enable. In idle the oscillator enable stays on, and so do the watchdog and clock-monitor enables (each follows its configuration input). A free-running wake timer also keeps counting. In halt the oscillator enable and the watchdog enable are off and the wake timer holds its value. The clock-monitor enable still follows its configuration input in halt.

Idle ends in three ways: an external wake request, a reset, or a toggle of the wake timer's top bit. That bit toggles once every 4096 counted cycles. Each toggle sets a sticky pending flag, whether or not the block is idle. Software clears the flag with a clear pulse. When the interrupt enable is set, the flag drives an interrupt request. Halt ends only on reset or an external wake request.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output is run (0), the core clock enable and oscillator enable are 1, and the pending flag and interrupt request are 0. The wake timer is 0.
- R2: The mode output encodes run=0, settle=1, idle=2, halt=3. An idle request in run enters settle at the next edge. The core clock enable, a registered output, stays 1 through two settle cycles and goes to 0 at the edge that enters idle.
- R3: A halt request in run takes the same two-cycle settle path into halt. When idle and halt requests come in the same cycle, halt wins.
- R4: Idle and halt requests are ignored in any mode other than run.
- R5: In run, settle and idle, the watchdog enable equals its configuration input and the oscillator enable is 1. The clock-monitor enable always equals its configuration input.
- R6: In halt the oscillator enable and the watchdog enable are 0. The clock-monitor enable still follows its configuration input.
- R7: The wake timer (13 bits) advances by one on every edge at which the mode is not halt, and holds its value in halt. A change of timer bit 12 while idle returns the block to run at that edge, with the core clock enable back at 1.
- R8: An external wake request returns the block to run at the next edge from idle, from halt, or from settle, which cancels the pending entry.
- R9: Each change of timer bit 12 sets the pending flag. The flag stays set until a clear pulse or reset. If a clear pulse and a toggle fall in the same cycle, the flag ends up set.
- R10: The interrupt request is 1 exactly when the pending flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | One-cycle request to enter idle |
| halt_req | input | 1 | One-cycle request to enter halt |
| wake_req | input | 1 | External wake request |
| pend_clr | input | 1 | Software clear of the pending flag |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| wdog_cfg | input | 1 | Watchdog enable configuration |
| cmon_cfg | input | 1 | Clock-monitor enable configuration |
| core_clk_en | output | 1 | Registered core clock enable |
| osc_en | output | 1 | Oscillator enable |
| wdog_en | output | 1 | Watchdog enable |
| cmon_en | output | 1 | Clock-monitor enable |
| tmr_pend | output | 1 | Sticky wake-timer pending flag |
| tmr_irq | output | 1 | Timer interrupt request |
| mode | output | 2 | Current mode (0 run, 1 settle, 2 idle, 3 halt) |

## Verification
Two events can land on the same edge: the toggle of timer bit 12 and a software clear of the pending flag. The bench provokes this by waiting until its own timer count is one step short of a multiple of 4096. At that cycle it raises the clear pulse together with an external wake request while the block is idle. It then requires the flag to be set, and the mode to be run, on the following cycle. A cycle-level scoreboard compares every output on every cycle, including across the long halt in which the timer must stay frozen.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        MD_RUN    = 2'd0,
        MD_SETTLE = 2'd1,
        MD_IDLE   = 2'd2,
        MD_HALT   = 2'd3
    } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int TMR_W    = 13,
    parameter int WAKE_BIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (run_i) begin
            st_d.cnt = st_q.cnt + TMR_W'(1);
            tick_o   = st_d.cnt[WAKE_BIT] ^ st_q.cnt[WAKE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> st_q.cnt == $past(st_q.cnt) + TMR_W'(1));
    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/lpm_pend_flag.sv
module lpm_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic pend_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i)     st_d.pend = 1'b1;
        else if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.pend & irq_en_i;

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend_o);
    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req_i,
    input  logic      halt_req_i,
    input  logic      wake_i,
    input  logic      tick_i,
    input  logic      wdog_cfg_i,
    input  logic      cmon_cfg_i,
    output lpm_mode_e mode_o,
    output logic      clk_en_o,
    output logic      osc_en_o,
    output logic      wdog_en_o,
    output logic      cmon_en_o,
    output logic      tmr_run_o
);
    localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);

    typedef struct packed {
        lpm_mode_e       mode;
        logic            tgt_halt;
        logic [SC_W-1:0] cnt;
        logic            clk_en;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MD_RUN: begin
                if (halt_req_i || idle_req_i) begin
                    st_d.mode     = MD_SETTLE;
                    st_d.tgt_halt = halt_req_i;
                    st_d.cnt      = '0;
                end
            end
            MD_SETTLE: begin
                if (wake_i) begin
                    st_d.mode = MD_RUN;
                end else if (st_q.cnt == SC_LAST) begin
                    st_d.mode = st_q.tgt_halt ? MD_HALT : MD_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + SC_W'(1);
                end
            end
            MD_IDLE: begin
                if (wake_i || tick_i) st_d.mode = MD_RUN;
            end
            MD_HALT: begin
                if (wake_i) st_d.mode = MD_RUN;
            end
            default: st_d.mode = MD_RUN;
        endcase
        st_d.clk_en = (st_d.mode != MD_IDLE) && (st_d.mode != MD_HALT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= MD_RUN;
            st_q.tgt_halt <= 1'b0;
            st_q.cnt      <= '0;
            st_q.clk_en   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign clk_en_o  = st_q.clk_en;
    assign osc_en_o  = (st_q.mode != MD_HALT);
    assign wdog_en_o = wdog_cfg_i && (st_q.mode != MD_HALT);
    assign cmon_en_o = cmon_cfg_i;
    assign tmr_run_o = (st_q.mode != MD_HALT);

    // R2
    idle_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_RUN && idle_req_i && !halt_req_i) |=> (mode_o == MD_SETTLE && clk_en_o));
    // R3
    halt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_RUN && halt_req_i) |=> (mode_o == MD_SETTLE && st_q.tgt_halt));
    // R7
    tick_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_IDLE && tick_i) |=> (mode_o == MD_RUN && clk_en_o));
    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_HALT && !wake_i) |=> mode_o == MD_HALT);
    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MD_RUN && wake_i) |=> (mode_o == MD_RUN && clk_en_o));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int TMR_W      = 13,
    parameter int WAKE_BIT   = 12,
    parameter int SETTLE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic       halt_req,
    input  logic       wake_req,
    input  logic       pend_clr,
    input  logic       tmr_irq_en,
    input  logic       wdog_cfg,
    input  logic       cmon_cfg,
    output logic       core_clk_en,
    output logic       osc_en,
    output logic       wdog_en,
    output logic       cmon_en,
    output logic       tmr_pend,
    output logic       tmr_irq,
    output logic [1:0] mode
);
    logic      tick_w;
    logic      run_w;
    lpm_mode_e mode_w;

    lpm_wake_timer #(
        .TMR_W    (TMR_W),
        .WAKE_BIT (WAKE_BIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .tick_o (tick_w)
    );

    lpm_pend_flag u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .clr_i    (pend_clr),
        .irq_en_i (tmr_irq_en),
        .pend_o   (tmr_pend),
        .irq_o    (tmr_irq)
    );

    lpm_seq #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req_i (idle_req),
        .halt_req_i (halt_req),
        .wake_i     (wake_req),
        .tick_i     (tick_w),
        .wdog_cfg_i (wdog_cfg),
        .cmon_cfg_i (cmon_cfg),
        .mode_o     (mode_w),
        .clk_en_o   (core_clk_en),
        .osc_en_o   (osc_en),
        .wdog_en_o  (wdog_en),
        .cmon_en_o  (cmon_en),
        .tmr_run_o  (run_w)
    );

    assign mode = mode_w;
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, halt_req = 0, wake_req = 0, pend_clr = 0;
    logic tmr_irq_en = 0, wdog_cfg = 1, cmon_cfg = 0;
    logic core_clk_en, osc_en, wdog_en, cmon_en, tmr_pend, tmr_irq;
    logic [1:0] mode;

    always #5 clk = ~clk;

    lpm_ctrl u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .halt_req(halt_req),
        .wake_req(wake_req), .pend_clr(pend_clr), .tmr_irq_en(tmr_irq_en),
        .wdog_cfg(wdog_cfg), .cmon_cfg(cmon_cfg), .core_clk_en(core_clk_en),
        .osc_en(osc_en), .wdog_en(wdog_en), .cmon_en(cmon_en),
        .tmr_pend(tmr_pend), .tmr_irq(tmr_irq), .mode(mode)
    );

    typedef struct {
        int md; int ce; int osc; int wd; int cm; int pd; int irq;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done   = 0;

    // requirement model state
    int m_mode = 0, m_cnt = 0, m_tgt = 0, m_tmr = 0, m_pend = 0;

    task automatic chk(string rq, string fld, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s (%s) %s actual=%0d expected=%0d", rq, phase, fld, act, expv);
        end
    endtask

    // model: pushes the expected post-edge outputs (R1..R10)
    always @(posedge clk) begin
        exp_t e;
        int   tick;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_tgt = 0; m_tmr = 0; m_pend = 0;
        end else begin
            tick = 0;
            if (m_mode != 3) begin
                if ((((m_tmr + 1) >> 12) & 1) != ((m_tmr >> 12) & 1)) tick = 1;
                m_tmr = (m_tmr + 1) % 8192;
            end
            case (m_mode)
                0: if (halt_req || idle_req) begin
                       m_mode = 1; m_tgt = halt_req ? 1 : 0; m_cnt = 0;
                   end
                1: if (wake_req) m_mode = 0;
                   else if (m_cnt == 1) m_mode = m_tgt ? 3 : 2;
                   else m_cnt++;
                2: if (wake_req || tick) m_mode = 0;
                default: if (wake_req) m_mode = 0;
            endcase
            if (tick) m_pend = 1;
            else if (pend_clr) m_pend = 0;
        end
        e.md  = m_mode;
        e.ce  = (m_mode == 2 || m_mode == 3) ? 0 : 1;
        e.osc = (m_mode == 3) ? 0 : 1;
        e.wd  = (m_mode == 3) ? 0 : int'(wdog_cfg);
        e.cm  = int'(cmon_cfg);
        e.pd  = m_pend;
        e.irq = m_pend & int'(tmr_irq_en);
        sb_q.push_back(e);
    end

    // monitor
    always @(posedge clk) begin
        exp_t e;
        #3;
        if (!done && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk("R2", "mode", int'(mode), e.md);
            chk("R2", "core_clk_en", int'(core_clk_en), e.ce);
            chk("R6", "osc_en", int'(osc_en), e.osc);
            chk("R5", "wdog_en", int'(wdog_en), e.wd);
            chk("R5", "cmon_en", int'(cmon_en), e.cm);
            chk("R9", "tmr_pend", int'(tmr_pend), e.pd);
            chk("R10", "tmr_irq", int'(tmr_irq), e.irq);
        end
    end

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in phase %s", phase);
        report();
    end

    task automatic wait_mode(int m);
        for (int i = 0; i < 20000 && int'(mode) != m; i++) @(negedge clk);
    endtask

    task automatic wait_pre_tick();
        @(negedge clk);
        while (((m_tmr + 1) % 4096) != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode", int'(mode), 0);
        chk("R1", "core_clk_en", int'(core_clk_en), 1);
        chk("R1", "osc_en", int'(osc_en), 1);
        chk("R1", "tmr_pend", int'(tmr_pend), 0);
        chk("R1", "tmr_irq", int'(tmr_irq), 0);

        // R2 idle entry with 2-cycle settle
        phase = "R2";
        idle_req = 1; @(negedge clk); idle_req = 0;
        chk("R2", "settle clk_en", int'(core_clk_en), 1);
        @(negedge clk);
        chk("R2", "settle mode", int'(mode), 1);
        @(negedge clk);
        chk("R2", "idle mode", int'(mode), 2);
        chk("R5", "idle osc_en", int'(osc_en), 1);

        // R7 timer bit 12 toggle ends idle; R10 irq masked then enabled
        phase = "R7";
        wait_mode(0);
        chk("R7", "exit mode", int'(mode), 0);
        chk("R9", "pend after toggle", int'(tmr_pend), 1);
        chk("R10", "irq masked", int'(tmr_irq), 0);
        tmr_irq_en = 1; @(negedge clk);
        chk("R10", "irq enabled", int'(tmr_irq), 1);
        pend_clr = 1; @(negedge clk); pend_clr = 0;
        chk("R9", "pend cleared", int'(tmr_pend), 0);

        // R4 requests ignored in idle; R8 wake from idle
        phase = "R4";
        idle_req = 1; @(negedge clk); idle_req = 0;
        wait_mode(2);
        halt_req = 1; idle_req = 1; @(negedge clk); halt_req = 0; idle_req = 0;
        repeat (3) @(negedge clk);
        chk("R4", "still idle", int'(mode), 2);
        phase = "R8";
        wake_req = 1; @(negedge clk); wake_req = 0;
        chk("R8", "idle wake", int'(mode), 0);

        // R3 halt priority, R6 halt outputs, R7 frozen timer
        phase = "R3";
        cmon_cfg = 1;
        idle_req = 1; halt_req = 1; @(negedge clk); idle_req = 0; halt_req = 0;
        repeat (2) @(negedge clk);
        chk("R3", "halt mode", int'(mode), 3);
        chk("R6", "halt wdog", int'(wdog_en), 0);
        chk("R6", "halt cmon", int'(cmon_en), 1);
        phase = "R7";
        repeat (5000) @(negedge clk);
        chk("R7", "no pend in halt", int'(tmr_pend), 0);
        phase = "R8";
        wake_req = 1; @(negedge clk); wake_req = 0;
        chk("R8", "halt wake", int'(mode), 0);

        // R8 abort during settle
        idle_req = 1; @(negedge clk); idle_req = 0;
        wake_req = 1; @(negedge clk); wake_req = 0;
        chk("R8", "settle abort", int'(mode), 0);
        repeat (3) @(negedge clk);
        chk("R8", "stays run", int'(mode), 0);

        // R9 toggle and clear in the same cycle, with wake in idle
        phase = "R9";
        wdog_cfg = 0; tmr_irq_en = 0;
        idle_req = 1; @(negedge clk); idle_req = 0;
        wait_pre_tick();
        pend_clr = 1; wake_req = 1;
        @(negedge clk);
        pend_clr = 0; wake_req = 0;
        chk("R9", "set wins over clear", int'(tmr_pend), 1);
        chk("R8", "run after collision", int'(mode), 0);
        repeat (10) @(negedge clk);
        report();
    end
endmodule